// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block is a first-in first-out buffer for 18-bit words that are produced in one clock domain and consumed in another. A producer presents a word and pulls its active-low write strobe low; the word is captured on the next rising edge of the write clock unless the buffer is already full. A consumer pulls its active-low read strobe low, and on the next rising edge of the read clock the oldest stored word moves into an output register, unless the buffer is empty. When a read is refused because nothing is stored, the output register keeps the last word it delivered.

Five active-low status outputs describe the fill level: empty and almost-empty are evaluated against the read clock, while half-full, almost-full and full are evaluated against the write clock. The two "almost" thresholds are distances supplied as inputs by a separate programming block: almost-empty means the stored count is no more than the empty distance, and almost-full means the free space is no more than the full distance. Each side learns the other side's position from a pointer passed across the boundary in Gray code through a two-stage synchronizer, so flags on either side may lag the true fill level by a few cycles but never overstate the room or the data available. An active-low output enable gates the data bus; with it high the bus reads as zero and a drive indicator is low.

Top module: `dcfifo_flags`

## Requirements
- R1: After the active-low reset, the FIFO is empty: empty_n = 0, almost_empty_n = 0, half_full_n = 1, almost_full_n = 1 (for a full distance below the depth), full_n = 1, and the output register holds all zeros.
- R2: Write and read strobes that are low while reset is held low store nothing and read nothing; after release the FIFO is still empty.
- R3: On a rising write-clock edge with wr_en_n = 0 and full_n = 1, wr_data is stored; words leave in the order they were written.
- R4: On a rising read-clock edge with rd_en_n = 0 and empty_n = 1, the oldest stored word is loaded into the output register and removed from the FIFO.
- R5: A write attempted while full_n = 0 is dropped: the stored contents and their order are unchanged.
- R6: A read attempted while empty_n = 0 is refused and the output register keeps the last word read.
- R7: Once both sides have settled, almost_empty_n = 0 exactly when the stored count is less than or equal to ae_offset.
- R8: Once settled, almost_full_n = 0 exactly when DEPTH minus the stored count is less than or equal to af_offset.
- R9: Once settled, half_full_n = 0 exactly when the stored count is greater than DEPTH/2.
- R10: Once settled, full_n = 0 exactly when the count equals DEPTH, and empty_n = 0 exactly when the count is zero.
- R11: With oe_n = 1, rd_data is all zeros and rd_drive = 0; with oe_n = 0, rd_data equals the output register and rd_drive = 1.
- R12: DEPTH is a power-of-two parameter (256 by default; 1024 and 4096 also intended) and every flag threshold and the full condition scale with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ae_offset | input | OFS_W | Distance from empty at which almost-empty asserts |
| af_offset | input | OFS_W | Distance from full at which almost-full asserts |
| wr_en_n | input | 1 | Active-low write strobe |
| wr_data | input | 18 | Word to be written |
| rd_en_n | input | 1 | Active-low read strobe |
| oe_n | input | 1 | Active-low output enable for the data bus |
| rd_data | output | 18 | Output register gated by oe_n |
| rd_drive | output | 1 | High while the data bus is enabled |
| empty_n | output | 1 | Active-low empty (read clock) |
| almost_empty_n | output | 1 | Active-low almost-empty (read clock) |
| half_full_n | output | 1 | Active-low half-full (write clock) |
| almost_full_n | output | 1 | Active-low almost-full (write clock) |
| full_n | output | 1 | Active-low full (write clock) |

## Verification
The hardest state to reach from the ports is the exact fill level at which each threshold flips, because the flags of each side see the opposite pointer only after synchronizer delay. The stimulus therefore moves the FIFO one word at a time from empty to full and back to empty, letting both clock domains settle after every step, and repeats the sweep with two different pairs of distances so that every count from zero to the depth is compared against arithmetically derived flag values. Writes at full and reads at empty are issued at the ends of each sweep, and the following read order and held output word show whether they leaked through.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int unsigned DATA_W = 18;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/dcf_rst_sync.sv
module dcf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign srst_n = stage2_q;
endmodule

// File: rtl/dcf_gray_xfer.sv
module dcf_gray_xfer #(
  parameter int unsigned PW = 9
) (
  input  logic          dst_clk,
  input  logic          dst_rst_n,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  logic [PW-1:0] meta_q;
  logic [PW-1:0] sync_q;
  logic [PW-1:0] bin_d;

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    bin_d[PW-1] = sync_q[PW-1];
    for (int i = int'(PW) - 2; i >= 0; i--) begin
      bin_d[i] = bin_d[i+1] ^ sync_q[i];
    end
  end

  assign bin_out = bin_d;
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned OFS_W = 12,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned PW = AW + 1
) (
  input  logic             wclk,
  input  logic             wrst_n,
  input  logic             wr_en_n,
  input  logic [OFS_W-1:0] af_offset,
  input  logic [PW-1:0]    rbin_sync,
  output logic             mem_we,
  output logic [AW-1:0]    mem_waddr,
  output logic [PW-1:0]    wgray,
  output logic             full_n,
  output logic             almost_full_n,
  output logic             half_full_n
);
  localparam int unsigned CW = (PW > OFS_W) ? PW : OFS_W;
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);

  logic [PW-1:0] wbin_q, wbin_d;
  logic [PW-1:0] wgray_q, wgray_d;
  logic [PW-1:0] wcount;
  logic [PW-1:0] wfree;
  logic          full;
  logic          wr_ok;

  // occupancy as seen from the write clock (read pointer lags, so count is pessimistic)
  assign wcount = wbin_q - rbin_sync;
  assign wfree  = FULL_CNT - wcount;
  assign full   = (wcount == FULL_CNT);
  assign wr_ok  = !wr_en_n && !full;

  always_comb begin
    wbin_d  = wbin_q;
    if (wr_ok) begin
      wbin_d = wbin_q + PW'(1);
    end
    wgray_d = wbin_d ^ (wbin_d >> 1);
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  assign mem_we        = wr_ok;
  assign mem_waddr     = wbin_q[AW-1:0];
  assign wgray         = wgray_q;
  assign full_n        = !full;
  assign almost_full_n = !(CW'(wfree) <= CW'(af_offset));
  assign half_full_n   = !(wcount > HALF_CNT);

  // R5: a refused write leaves the write pointer untouched
  a_r5_no_overflow: assert property (@(posedge wclk) disable iff (!wrst_n)
    (!wr_en_n && full) |=> $stable(wbin_q));

  // R10: occupancy never exceeds the depth
  a_r10_wr_count_bound: assert property (@(posedge wclk) disable iff (!wrst_n)
    wcount <= FULL_CNT);

  // R3: the pointer sent across changes by at most one bit per cycle
  a_r3_gray_one_step: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned OFS_W = 12,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned PW = AW + 1
) (
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rd_en_n,
  input  logic [OFS_W-1:0]  ae_offset,
  input  logic [PW-1:0]     wbin_sync,
  input  dcf_pkg::word_t    mem_rdata,
  output logic [AW-1:0]     mem_raddr,
  output logic [PW-1:0]     rgray,
  output dcf_pkg::word_t    out_word,
  output logic              empty_n,
  output logic              almost_empty_n
);
  localparam int unsigned CW = (PW > OFS_W) ? PW : OFS_W;
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

  logic [PW-1:0]  rbin_q, rbin_d;
  logic [PW-1:0]  rgray_q, rgray_d;
  logic [PW-1:0]  rcount;
  logic           empty;
  logic           rd_ok;
  dcf_pkg::word_t out_q, out_d;

  // occupancy as seen from the read clock (write pointer lags, so count is pessimistic)
  assign rcount = wbin_sync - rbin_q;
  assign empty  = (rcount == '0);
  assign rd_ok  = !rd_en_n && !empty;

  always_comb begin
    rbin_d = rbin_q;
    out_d  = out_q;
    if (rd_ok) begin
      rbin_d = rbin_q + PW'(1);
      out_d  = mem_rdata;
    end
    rgray_d = rbin_d ^ (rbin_d >> 1);
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      out_q   <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
      out_q   <= out_d;
    end
  end

  assign mem_raddr      = rbin_q[AW-1:0];
  assign rgray          = rgray_q;
  assign out_word       = out_q;
  assign empty_n        = !empty;
  assign almost_empty_n = !(CW'(rcount) <= CW'(ae_offset));

  // R6: a refused read keeps both the pointer and the last delivered word
  a_r6_hold_on_empty: assert property (@(posedge rclk) disable iff (!rrst_n)
    (!rd_en_n && empty) |=> ($stable(out_q) && $stable(rbin_q)));

  // R4: an accepted read advances the pointer by exactly one
  a_r4_read_advance: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_ok |=> (rbin_q == $past(rbin_q) + PW'(1)));

  // R10: the read-side count stays within the depth
  a_r10_rd_count_bound: assert property (@(posedge rclk) disable iff (!rrst_n)
    rcount <= FULL_CNT);
endmodule

// File: rtl/dcfifo_flags.sv
module dcfifo_flags #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned OFS_W = 12,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned PW = AW + 1
) (
  input  logic                        wr_clk,
  input  logic                        rd_clk,
  input  logic                        rst_n,
  input  logic [OFS_W-1:0]            ae_offset,
  input  logic [OFS_W-1:0]            af_offset,
  input  logic                        wr_en_n,
  input  logic [dcf_pkg::DATA_W-1:0]  wr_data,
  input  logic                        rd_en_n,
  input  logic                        oe_n,
  output logic [dcf_pkg::DATA_W-1:0]  rd_data,
  output logic                        rd_drive,
  output logic                        empty_n,
  output logic                        almost_empty_n,
  output logic                        half_full_n,
  output logic                        almost_full_n,
  output logic                        full_n
);
  logic           wrst_n, rrst_n;
  logic           mem_we;
  logic [AW-1:0]  mem_waddr, mem_raddr;
  logic [PW-1:0]  wgray, rgray;
  logic [PW-1:0]  wbin_at_rd, rbin_at_wr;
  dcf_pkg::word_t mem_rdata;
  dcf_pkg::word_t out_word;
  dcf_pkg::word_t store_q [DEPTH];

  dcf_rst_sync u_wrst (.clk(wr_clk), .arst_n(rst_n), .srst_n(wrst_n));
  dcf_rst_sync u_rrst (.clk(rd_clk), .arst_n(rst_n), .srst_n(rrst_n));

  dcf_gray_xfer #(.PW(PW)) u_w2r (
    .dst_clk(rd_clk), .dst_rst_n(rrst_n), .gray_in(wgray), .bin_out(wbin_at_rd)
  );
  dcf_gray_xfer #(.PW(PW)) u_r2w (
    .dst_clk(wr_clk), .dst_rst_n(wrst_n), .gray_in(rgray), .bin_out(rbin_at_wr)
  );

  dcf_wr_side #(.DEPTH(DEPTH), .OFS_W(OFS_W)) u_wr (
    .wclk(wr_clk), .wrst_n(wrst_n), .wr_en_n(wr_en_n), .af_offset(af_offset),
    .rbin_sync(rbin_at_wr), .mem_we(mem_we), .mem_waddr(mem_waddr), .wgray(wgray),
    .full_n(full_n), .almost_full_n(almost_full_n), .half_full_n(half_full_n)
  );

  dcf_rd_side #(.DEPTH(DEPTH), .OFS_W(OFS_W)) u_rd (
    .rclk(rd_clk), .rrst_n(rrst_n), .rd_en_n(rd_en_n), .ae_offset(ae_offset),
    .wbin_sync(wbin_at_rd), .mem_rdata(mem_rdata), .mem_raddr(mem_raddr),
    .rgray(rgray), .out_word(out_word), .empty_n(empty_n),
    .almost_empty_n(almost_empty_n)
  );

  // storage array: written on the write clock, read combinationally by the read side
  always_ff @(posedge wr_clk) begin
    if (mem_we) begin
      store_q[mem_waddr] <= wr_data;
    end
  end

  assign mem_rdata = store_q[mem_raddr];
  assign rd_drive  = !oe_n;
  assign rd_data   = oe_n ? '0 : out_word;
endmodule

// File: tb/dcfifo_flags_tb_top.sv
`timescale 1ns/1ps
module dcfifo_flags_tb_top;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned OFS_W = 12;

  logic             wr_clk = 1'b0;
  logic             rd_clk = 1'b0;
  logic             rst_n;
  logic [OFS_W-1:0] ae_offset, af_offset;
  logic             wr_en_n, rd_en_n, oe_n;
  logic [17:0]      wr_data;
  logic [17:0]      rd_data;
  logic             rd_drive, empty_n, almost_empty_n, half_full_n, almost_full_n, full_n;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  int          count = 0;
  bit          done  = 0;

  always #5 wr_clk = ~wr_clk;
  always #7 rd_clk = ~rd_clk;

  dcfifo_flags #(.DEPTH(DEPTH), .OFS_W(OFS_W)) dut_i (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .ae_offset(ae_offset), .af_offset(af_offset),
    .wr_en_n(wr_en_n), .wr_data(wr_data), .rd_en_n(rd_en_n), .oe_n(oe_n),
    .rd_data(rd_data), .rd_drive(rd_drive), .empty_n(empty_n),
    .almost_empty_n(almost_empty_n), .half_full_n(half_full_n),
    .almost_full_n(almost_full_n), .full_n(full_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (count %0d)", req, act, exp, count);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic logic [17:0] pattern(input int pass, input int k);
    return 18'((pass * 32'h1_2345) ^ (k * 32'h0_0F1D) ^ 32'h2_A5A5);
  endfunction

  task automatic settle();
    repeat (6) @(negedge wr_clk);
    repeat (6) @(negedge rd_clk);
  endtask

  task automatic push(input logic [17:0] d);
    @(negedge wr_clk);
    wr_en_n = 1'b0;
    wr_data = d;
    @(negedge wr_clk);
    wr_en_n = 1'b1;
  endtask

  task automatic pop();
    @(negedge rd_clk);
    rd_en_n = 1'b0;
    @(negedge rd_clk);
    rd_en_n = 1'b1;
  endtask

  // expected flags derived from the current count and the distances
  task automatic check_flags();
    check("R10 empty_n", 32'(empty_n), 32'(count != 0));
    check("R10 full_n", 32'(full_n), 32'(count != DEPTH));
    check("R7 almost_empty_n", 32'(almost_empty_n), 32'(!(count <= int'(ae_offset))));
    check("R8 almost_full_n", 32'(almost_full_n), 32'(!((DEPTH - count) <= int'(af_offset))));
    check("R9 half_full_n", 32'(half_full_n), 32'(!(count > DEPTH / 2)));
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R2: strobes held low during reset must do nothing
    rst_n     = 1'b0;
    wr_en_n   = 1'b0;
    rd_en_n   = 1'b0;
    oe_n      = 1'b0;
    wr_data   = 18'h1_2345;
    ae_offset = OFS_W'(2);
    af_offset = OFS_W'(3);
    repeat (6) @(negedge wr_clk);
    wr_en_n = 1'b1;
    rd_en_n = 1'b1;
    @(negedge wr_clk);
    rst_n = 1'b1;
    settle();
    // R1 reset state, R2 nothing got in
    check_flags();
    check("R1 output register", 32'(rd_data), 32'h0);
    check("R2 empty after reset", 32'(empty_n), 32'h0);
    pop();
    check("R2 read at empty after reset", 32'(rd_data), 32'h0);

    for (int pass = 0; pass < 2; pass++) begin
      if (pass == 1) begin
        ae_offset = OFS_W'(0);
        af_offset = OFS_W'(DEPTH - 1);
        settle();
        check_flags();
      end
      // fill sweep: R3, R7-R10, R12
      for (int k = 1; k <= int'(DEPTH); k++) begin
        push(pattern(pass, k));
        count++;
        settle();
        check_flags();
      end
      // R5: write at full must be dropped
      push(18'h3_FFFF);
      settle();
      check("R5 full_n after extra write", 32'(full_n), 32'h0);
      // drain sweep: R3, R4 order and flags
      for (int k = 1; k <= int'(DEPTH); k++) begin
        pop();
        count--;
        check("R4 R3 word order", 32'(rd_data), 32'(pattern(pass, k)));
        settle();
        check_flags();
      end
      // R6: read at empty keeps last word; R5 extra word never appears
      pop();
      check("R6 hold last word", 32'(rd_data), 32'(pattern(pass, DEPTH)));
      settle();
      check("R6 still empty", 32'(empty_n), 32'h0);
    end

    // R11: output enable gating
    oe_n = 1'b1;
    #1;
    check("R11 bus zero when disabled", 32'(rd_data), 32'h0);
    check("R11 drive low when disabled", 32'(rd_drive), 32'h0);
    oe_n = 1'b0;
    #1;
    check("R11 bus restored", 32'(rd_data), 32'(pattern(1, DEPTH)));
    check("R11 drive high when enabled", 32'(rd_drive), 32'h1);

    finish_run();
  end
endmodule